// File: doc/BRIEF.md
# Banked-Register Add Execution Unit

This unit executes the two add instructions of a small 8-bit accumulator machine. It receives one 16-bit instruction word with a valid strobe and runs it through four internal phases: decode, operand read, add, and destination write. The unit holds the working register W, a 4-bit bank selector, a five-flag status register and a 4096-byte data memory. The data memory is addressed either through the bank selector or through a fixed shortcut window.

The literal form adds an 8-bit constant to W. The register form adds W to a memory byte and sends the sum to W or back to that byte. Both forms set the negative, overflow, carry, half carry and zero flags. A word that is neither form passes through the four phases and changes nothing. A one-cycle completion pulse follows every accepted word, and a new word can enter during the final phase of the previous one.

The enclosing core owns the other instructions. It seeds W, the bank selector and memory through a load port while the unit is idle, and it observes memory through a read-only address port.

Top module: `addx_unit`

## Requirements
- R1: A word whose upper byte is 0Fh adds its lower byte k to W and leaves the 8-bit sum in W (W=10h, k=15h gives W=25h).
- R2: A word whose top six bits are 001001 is a register add: bit 9 is the destination bit d, bit 8 is the bank bit a, and the low byte is the address f. With d=0 the sum of W and the memory byte goes to W and the byte is unchanged (W=17h, byte C2h gives W=D9h, byte C2h).
- R3: A register add with d=1 writes the sum to the addressed byte and leaves W unchanged.
- R4: A register add with a=1 addresses memory location {bank selector, f}.
- R5: A register add with a=0 addresses location 000h+f when f is below 60h, and F00h+f when f is 60h or above, whatever the bank selector holds.
- R6: status_out bit 0 is the carry out of bit 7 and bit 1 is the carry out of bit 3.
- R7: status_out bit 2 is set when the 8-bit result is zero, bit 3 is set when both addends have the same sign and the result's sign differs, and bit 4 is result bit 7.
- R8: A word is accepted on a clock edge where instr_valid is high and the unit is idle or in its fourth phase; it is ignored otherwise. Results become visible at the fourth edge after acceptance. done is high for exactly the cycle after that edge. busy is high from acceptance until that edge.
- R9: A word matching neither form changes no register, memory byte or flag, and still produces the done pulse.
- R10: ld_valid with ld_kind 0 loads W, 1 loads the bank selector, and 2 loads the memory byte at ld_addr with ld_data, at the next edge. Kind 3 does nothing. The load is ignored while busy is high.
- R11: After reset, W, the bank selector and the status register are zero, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 16 | Instruction word |
| ld_valid | input | 1 | Load request from the enclosing core |
| ld_kind | input | 2 | Load target: 0 W, 1 bank selector, 2 memory, 3 none |
| ld_addr | input | 12 | Memory address for a memory load |
| ld_data | input | 8 | Load value |
| mem_rd_addr | input | 12 | Observation address into data memory |
| mem_rd_data | output | 8 | Memory byte at mem_rd_addr |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| w_out | output | 8 | Working register |
| bsr_out | output | 4 | Bank selector |
| status_out | output | 5 | Flags {N, OV, Z, DC, C} |

## Verification
The bench seeds state through the load port before each case. A bad bank address or a bad access-window split shows up as a wrong sum on w_out at the fourth edge after acceptance, or as a byte that changes at an unexpected mem_rd_addr. A wrong adder carry or flag term shows on status_out in that same cycle. An early or leaked write shows in one of the three cycles before that edge, because W, the flags and memory must hold steady while busy is high.

// File: rtl/addx_pkg.sv
package addx_pkg;

    localparam int WORD_W = 16;
    localparam int ARG_W  = 8;

    localparam logic [7:0] LIT_OPC = 8'h0F;
    localparam logic [5:0] REG_OPC = 6'b001001;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_Q1   = 3'd1,
        PH_Q2   = 3'd2,
        PH_Q3   = 3'd3,
        PH_Q4   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        OP_NOP    = 2'd0,
        OP_ADDLIT = 2'd1,
        OP_ADDREG = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        LD_W    = 2'd0,
        LD_BSR  = 2'd1,
        LD_MEM  = 2'd2,
        LD_NONE = 2'd3
    } ld_kind_e;

    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } flags_t;

    typedef struct packed {
        op_e              op;
        logic             to_mem;
        logic             banked;
        logic [ARG_W-1:0] arg;
    } dec_t;

    function automatic dec_t decode_word(input logic [WORD_W-1:0] w);
        dec_t d;
        d.op     = OP_NOP;
        d.to_mem = 1'b0;
        d.banked = 1'b0;
        d.arg    = w[ARG_W-1:0];
        if (w[15:8] == LIT_OPC) begin
            d.op = OP_ADDLIT;
        end else if (w[15:10] == REG_OPC) begin
            d.op     = OP_ADDREG;
            d.to_mem = w[9];
            d.banked = w[8];
        end
        return d;
    endfunction

endpackage

// File: rtl/addx_seq.sv
module addx_seq
    import addx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   instr_valid,
    output phase_e phase,
    output logic   accept,
    output logic   busy,
    output logic   done
);

    phase_e phase_nx;

    assign accept = instr_valid && (phase == PH_IDLE || phase == PH_Q4);
    assign busy   = (phase != PH_IDLE);

    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE: phase_nx = accept ? PH_Q1 : PH_IDLE;
            PH_Q1:   phase_nx = PH_Q2;
            PH_Q2:   phase_nx = PH_Q3;
            PH_Q3:   phase_nx = PH_Q4;
            PH_Q4:   phase_nx = accept ? PH_Q1 : PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= (phase == PH_Q4);
        end
    end

    // R8: completion is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/addx_alu.sv
module addx_alu
    import addx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int HALF_W = DATA_W / 2
)(
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] sum,
    output flags_t            flags
);

    logic [HALF_W:0]          lo_sum;
    logic [DATA_W-HALF_W:0]   hi_sum;

    always_comb begin
        lo_sum = {1'b0, opa[HALF_W-1:0]} + {1'b0, opb[HALF_W-1:0]};
        hi_sum = {1'b0, opa[DATA_W-1:HALF_W]} + {1'b0, opb[DATA_W-1:HALF_W]}
               + {{(DATA_W-HALF_W){1'b0}}, lo_sum[HALF_W]};
        sum      = {hi_sum[DATA_W-HALF_W-1:0], lo_sum[HALF_W-1:0]};
        flags.c  = hi_sum[DATA_W-HALF_W];
        flags.dc = lo_sum[HALF_W];
        flags.n  = sum[DATA_W-1];
        flags.z  = (sum == '0);
        flags.ov = (opa[DATA_W-1] == opb[DATA_W-1]) && (sum[DATA_W-1] != opa[DATA_W-1]);
    end

endmodule

// File: rtl/addx_store.sv
module addx_store
    import addx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BSR_W  = 4,
    localparam int ADDR_W = BSR_W + DATA_W,
    localparam int DEPTH  = 1 << ADDR_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [1:0]        ld_kind,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_allow,
    input  logic              wr_w,
    input  logic              wr_mem,
    input  logic              wr_status,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  flags_t            wr_flags,
    input  logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    input  logic [ADDR_W-1:0] obs_addr,
    output logic [DATA_W-1:0] obs_data,
    output logic [DATA_W-1:0] w_q,
    output logic [BSR_W-1:0]  bsr_q,
    output flags_t            status_q
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic ld_go;

    assign ld_go    = ld_valid && ld_allow;
    assign op_data  = mem[op_addr];
    assign obs_data = mem[obs_addr];

    always_ff @(posedge clk) begin
        if (wr_mem) begin
            mem[wr_addr] <= wr_data;
        end else if (ld_go && ld_kind == LD_MEM) begin
            mem[ld_addr] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q      <= '0;
            bsr_q    <= '0;
            status_q <= '0;
        end else begin
            if (wr_w) begin
                w_q <= wr_data;
            end else if (ld_go && ld_kind == LD_W) begin
                w_q <= ld_data;
            end
            if (ld_go && ld_kind == LD_BSR) begin
                bsr_q <= ld_data[BSR_W-1:0];
            end
            if (wr_status) begin
                status_q <= wr_flags;
            end
        end
    end

    // R10: a load presented while busy leaves the bank selector alone
    p_ld_blocked_r10: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_allow && ld_kind == LD_BSR) |=> $stable(bsr_q));

endmodule

// File: rtl/addx_unit.sv
module addx_unit
    import addx_pkg::*;
#(
    parameter int          BSR_W        = 4,
    parameter logic [7:0]  ACCESS_SPLIT = 8'h60,
    localparam int DATA_W = ARG_W,
    localparam int ADDR_W = BSR_W + ARG_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [15:0]       instr_word,
    input  logic              ld_valid,
    input  logic [1:0]        ld_kind,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] mem_rd_addr,
    output logic [DATA_W-1:0] mem_rd_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] w_out,
    output logic [BSR_W-1:0]  bsr_out,
    output logic [4:0]        status_out
);

    phase_e            phase;
    logic              accept;
    logic [15:0]       instr_q;
    dec_t              dec_now, dec_q;
    logic [ADDR_W-1:0] addr_now, addr_q;
    logic [DATA_W-1:0] opa_q, opb_q, res_q, alu_sum, mem_opnd;
    flags_t            alu_flags, flg_q, status_q;
    logic [DATA_W-1:0] w_q;
    logic [BSR_W-1:0]  bsr_q;
    logic              commit, wr_w, wr_mem;

    addx_seq i_seq (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .phase       (phase),
        .accept      (accept),
        .busy        (busy),
        .done        (done)
    );

    // Q1: decode and bank address formation
    always_comb begin
        dec_now = decode_word(instr_q);
        if (dec_now.banked) begin
            addr_now = {bsr_q, dec_now.arg};
        end else if (dec_now.arg < ACCESS_SPLIT) begin
            addr_now = {{BSR_W{1'b0}}, dec_now.arg};
        end else begin
            addr_now = {{BSR_W{1'b1}}, dec_now.arg};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            instr_q <= '0;
            dec_q   <= '0;
            addr_q  <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
            res_q   <= '0;
            flg_q   <= '0;
        end else begin
            if (accept) begin
                instr_q <= instr_word;
            end
            if (phase == PH_Q1) begin
                dec_q  <= dec_now;
                addr_q <= addr_now;
            end
            if (phase == PH_Q2) begin
                opa_q <= w_q;
                opb_q <= (dec_q.op == OP_ADDREG) ? mem_opnd : dec_q.arg;
            end
            if (phase == PH_Q3) begin
                res_q <= alu_sum;
                flg_q <= alu_flags;
            end
        end
    end

    addx_alu #(.DATA_W(DATA_W)) i_alu (
        .opa   (opa_q),
        .opb   (opb_q),
        .sum   (alu_sum),
        .flags (alu_flags)
    );

    // Q4: destination write
    assign commit = (phase == PH_Q4) && (dec_q.op != OP_NOP);
    assign wr_w   = commit && (dec_q.op == OP_ADDLIT || !dec_q.to_mem);
    assign wr_mem = commit && (dec_q.op == OP_ADDREG) && dec_q.to_mem;

    addx_store #(.DATA_W(DATA_W), .BSR_W(BSR_W)) i_store (
        .clk       (clk),
        .rst       (rst),
        .ld_valid  (ld_valid),
        .ld_kind   (ld_kind),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .ld_allow  (!busy),
        .wr_w      (wr_w),
        .wr_mem    (wr_mem),
        .wr_status (commit),
        .wr_addr   (addr_q),
        .wr_data   (res_q),
        .wr_flags  (flg_q),
        .op_addr   (addr_q),
        .op_data   (mem_opnd),
        .obs_addr  (mem_rd_addr),
        .obs_data  (mem_rd_data),
        .w_q       (w_q),
        .bsr_q     (bsr_q),
        .status_q  (status_q)
    );

    assign w_out      = w_q;
    assign bsr_out    = bsr_q;
    assign status_out = status_q;

    // R8: architectural state holds during the first three phases
    p_state_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_Q1 || phase == PH_Q2 || phase == PH_Q3)
        |=> ($stable(w_q) && $stable(status_q) && $stable(bsr_q)));

    // R9: an unrecognised word leaves W and the flags untouched
    p_nop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_Q4 && dec_q.op == OP_NOP) |=> ($stable(w_q) && $stable(status_q)));

    // R7: after a write to W the N and Z flags agree with the new W
    p_flag_nz_r7: assert property (@(posedge clk) disable iff (rst)
        wr_w |=> (status_q.n == w_q[DATA_W-1]) && (status_q.z == (w_q == '0)));

    // R3: a memory-destination add keeps W
    p_memwr_keep_w_r3: assert property (@(posedge clk) disable iff (rst)
        wr_mem |=> $stable(w_q));

endmodule

// File: tb/test_addx_unit.sv
`timescale 1ns/1ps
module test_addx_unit;

    localparam int PERIOD = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [15:0] instr_word;
    logic        ld_valid;
    logic [1:0]  ld_kind;
    logic [11:0] ld_addr;
    logic [7:0]  ld_data;
    logic [11:0] mem_rd_addr;
    logic [7:0]  mem_rd_data;
    logic        busy, done;
    logic [7:0]  w_out;
    logic [3:0]  bsr_out;
    logic [4:0]  status_out;

    addx_unit i_addx_unit (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .ld_valid(ld_valid), .ld_kind(ld_kind), .ld_addr(ld_addr), .ld_data(ld_data),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .busy(busy), .done(done),
        .w_out(w_out), .bsr_out(bsr_out), .status_out(status_out)
    );

    always #(PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // behavioural reference state
    logic [7:0] m_w = 8'h00;
    logic [3:0] m_bsr = 4'h0;
    logic [4:0] m_st = 5'h00;
    logic [7:0] m_mem [4096];
    bit         m_known [4096];

    // pending effect of the instruction in flight
    int         p_kind;
    logic [7:0] p_val;
    logic [11:0] p_addr;
    logic [4:0] p_st;

    task automatic cmp(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req, bit e_done, bit e_busy);
        cmp(req, "w_out", int'(w_out), int'(m_w));
        cmp(req, "bsr_out", int'(bsr_out), int'(m_bsr));
        cmp(req, "status_out", int'(status_out), int'(m_st));
        cmp(req, "done", int'(done), int'(e_done));
        cmp(req, "busy", int'(busy), int'(e_busy));
        if (m_known[mem_rd_addr]) cmp(req, "mem_rd_data", int'(mem_rd_data), int'(m_mem[mem_rd_addr]));
    endtask

    task automatic model_eval(logic [15:0] wd);
        logic [7:0] a, b, r, f;
        logic [8:0] s;
        logic [4:0] lo;
        bit to_mem;
        p_kind = 0;
        to_mem = 1'b0;
        if (wd[15:8] == 8'h0F) begin
            a = m_w; b = wd[7:0];
        end else if (wd[15:10] == 6'b001001) begin
            f = wd[7:0];
            if (wd[8]) p_addr = {m_bsr, f};
            else if (f < 8'h60) p_addr = {4'h0, f};
            else p_addr = {4'hF, f};
            a = m_w; b = m_mem[p_addr]; to_mem = wd[9];
        end else begin
            return;
        end
        s  = {1'b0, a} + {1'b0, b};
        r  = s[7:0];
        lo = {1'b0, a[3:0]} + {1'b0, b[3:0]};
        p_st = {r[7], (a[7] == b[7]) && (r[7] != a[7]), (r == 8'h00), lo[4], s[8]};
        p_val = r;
        p_kind = to_mem ? 2 : 1;
    endtask

    task automatic model_apply();
        if (p_kind == 1) m_w = p_val;
        if (p_kind == 2) begin m_mem[p_addr] = p_val; m_known[p_addr] = 1'b1; end
        if (p_kind != 0) m_st = p_st;
        p_kind = 0;
    endtask

    task automatic load(logic [1:0] kind, logic [11:0] addr, logic [7:0] data, string req);
        ld_valid = 1'b1; ld_kind = kind; ld_addr = addr; ld_data = data;
        @(negedge clk);
        ld_valid = 1'b0;
        if (kind == 2'd0) m_w = data;
        if (kind == 2'd1) m_bsr = data[3:0];
        if (kind == 2'd2) begin m_mem[addr] = data; m_known[addr] = 1'b1; end
        compare_all(req, 1'b0, 1'b0);
    endtask

    task automatic exec(logic [15:0] wd, logic [11:0] obs, string req);
        model_eval(wd);
        mem_rd_addr = obs;
        instr_valid = 1'b1; instr_word = wd;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            instr_valid = 1'b0;
            compare_all(req, 1'b0, 1'b1);
        end
        @(negedge clk);
        model_apply();
        compare_all(req, 1'b1, 1'b0);
    endtask

    // stimulus on the port that must be ignored while the first phases run
    task automatic exec_disturbed(logic [15:0] wd, logic [11:0] obs);
        model_eval(wd);
        mem_rd_addr = obs;
        instr_valid = 1'b1; instr_word = wd;
        @(negedge clk);
        compare_all("R8", 1'b0, 1'b1);
        instr_valid = 1'b1; instr_word = 16'h0F01;
        ld_valid = 1'b1; ld_kind = 2'd0; ld_data = 8'hAA;
        @(negedge clk);
        instr_valid = 1'b0; ld_valid = 1'b0;
        compare_all("R10", 1'b0, 1'b1);
        ld_valid = 1'b1; ld_kind = 2'd2; ld_addr = obs; ld_data = 8'h3C;
        @(negedge clk);
        ld_valid = 1'b0;
        compare_all("R10", 1'b0, 1'b1);
        @(negedge clk);
        compare_all("R8", 1'b0, 1'b1);
        @(negedge clk);
        model_apply();
        compare_all("R8", 1'b1, 1'b0);
        @(negedge clk);
        compare_all("R8", 1'b0, 1'b0);
    endtask

    task automatic exec_pair(logic [15:0] w1, logic [15:0] w2, logic [11:0] obs);
        model_eval(w1);
        mem_rd_addr = obs;
        instr_valid = 1'b1; instr_word = w1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            instr_valid = 1'b0;
            compare_all("R8", 1'b0, 1'b1);
        end
        instr_valid = 1'b1; instr_word = w2;
        @(negedge clk);
        instr_valid = 1'b0;
        model_apply();
        model_eval(w2);
        compare_all("R8", 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            compare_all("R8", 1'b0, 1'b1);
        end
        @(negedge clk);
        model_apply();
        compare_all("R8", 1'b1, 1'b0);
    endtask

    initial begin
        #(PERIOD * 50000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin m_known[i] = 1'b0; m_mem[i] = 8'h00; end
        rst = 1'b1; instr_valid = 1'b0; instr_word = '0;
        ld_valid = 1'b0; ld_kind = 2'd3; ld_addr = '0; ld_data = '0; mem_rd_addr = '0;
        p_kind = 0; p_val = '0; p_addr = '0; p_st = '0;
        repeat (3) @(negedge clk);
        compare_all("R11", 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        compare_all("R11", 1'b0, 1'b0);

        // R10: loads while idle, kind 3 has no effect
        load(2'd3, 12'h000, 8'h77, "R10");
        load(2'd2, 12'h020, 8'hC2, "R10");

        // R1: literal add example
        load(2'd0, 12'h000, 8'h10, "R10");
        exec(16'h0F15, 12'h020, "R1");
        cmp("R1", "w_out", int'(w_out), 8'h25);

        // R2: register add to W
        load(2'd0, 12'h000, 8'h17, "R10");
        exec(16'h2420, 12'h020, "R2");
        cmp("R2", "w_out", int'(w_out), 8'hD9);
        cmp("R2", "mem_rd_data", int'(mem_rd_data), 8'hC2);

        // R3: register add back to memory
        exec(16'h2620, 12'h020, "R3");
        cmp("R3", "mem_rd_data", int'(mem_rd_data), 8'h9B);

        // R4: bank-selected operand
        load(2'd1, 12'h000, 8'h03, "R10");
        load(2'd2, 12'h345, 8'h7F, "R10");
        load(2'd2, 12'h045, 8'h00, "R10");
        load(2'd0, 12'h000, 8'h01, "R10");
        exec(16'h2545, 12'h345, "R4");
        exec(16'h2745, 12'h345, "R4");

        // R5: access window below and above the split
        load(2'd2, 12'h05F, 8'h11, "R10");
        load(2'd2, 12'h35F, 8'h22, "R10");
        load(2'd2, 12'hF60, 8'h33, "R10");
        load(2'd2, 12'h060, 8'h44, "R10");
        load(2'd2, 12'h360, 8'h55, "R10");
        load(2'd2, 12'hF80, 8'h01, "R10");
        load(2'd2, 12'h380, 8'h66, "R10");
        load(2'd0, 12'h000, 8'h00, "R10");
        exec(16'h245F, 12'h05F, "R5");
        exec(16'h2660, 12'hF60, "R5");
        exec(16'h2480, 12'hF80, "R5");

        // R6 / R7: flag corners
        load(2'd0, 12'h000, 8'hFF, "R10");
        exec(16'h0F01, 12'h020, "R6");
        load(2'd0, 12'h000, 8'h80, "R10");
        exec(16'h0F80, 12'h020, "R7");
        load(2'd0, 12'h000, 8'h08, "R10");
        exec(16'h0F08, 12'h020, "R6");
        load(2'd0, 12'h000, 8'h7F, "R10");
        exec(16'h0F01, 12'h020, "R7");
        load(2'd0, 12'h000, 8'h90, "R10");
        exec(16'h0F20, 12'h020, "R7");

        // R9: words matching neither form
        exec(16'h1234, 12'h020, "R9");
        exec(16'hFFFF, 12'h020, "R9");
        exec(16'h0E15, 12'h020, "R9");
        exec(16'h2820, 12'h020, "R9");
        exec(16'h2020, 12'h020, "R9");

        // R8 / R10: busy-time stimulus ignored, then back-to-back
        load(2'd0, 12'h000, 8'h05, "R10");
        exec_disturbed(16'h2620, 12'h020);
        exec_pair(16'h0F03, 16'h2420, 12'h020);
        exec_pair(16'h2620, 16'h0F10, 12'h020);

        repeat (2) begin
            @(negedge clk);
            compare_all("R8", 1'b0, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule